// File: doc/BRIEF.md
# Black Level Correction Loop

This block removes the DC offset from one 10-bit video channel using a digital closed loop. On every line, a window of black pixels is marked by a one-cycle start strobe on its first sample. The window length comes from a configuration field. The samples in the window are summed, and the sum is shifted down to form the line's black average. At the line-end pulse, the difference between a programmed black target and that average is scaled by a power of two and added to a fractional integrator. This gives a first-order low-pass filter whose time constant is between 32 and 4096 lines. The integer part of the integrator is the signed correction that a saturating adder applies to every pixel.

When the loop is switched off, the adder is bypassed and pixels pass through unchanged with the same one-cycle delay. A fixed offset code is then presented on a separate output for an external analog offset stage. A range bit halves the weight of the digital correction, for set-ups with a narrower offset span.

Top module: `blc_top`

## Requirements
- R1: The black window holds 2^(4+win_sel_i) consecutive samples, starting with the sample present on the `win_start_i` cycle: 00→16, 01→32, 10→64, 11→128. The line's black average is the window sum shifted right by 4+win_sel_i bits.
- R2: The integrator changes only on a `line_end_i` pulse that follows a completed window in the same line. It adds (target_i − average)·2^−(bw_sel_i+5) output LSBs, kept with 12 fractional bits. The correction is the floor of the integrator value.
- R3: `bw_sel_i` sets the loop time constant to 2^(bw_sel_i+5) lines: 000→32, 100→512, 111→4096.
- R4: The correction saturates to the signed range −512..+511 instead of wrapping.
- R5: In automatic mode (`auto_en_i`=1), `pix_o` = pix_i + correction when `half_range_i`=0. When `half_range_i`=1, `pix_o` = pix_i + floor(correction/2).
- R6: `pix_o` saturates to 0..1023.
- R7: In manual mode (`auto_en_i`=0), the adder is bypassed so that `pix_o` = pix_i, and `dac_code_o` = man_off_i. In this code, 0x200 is zero offset, 0x000 is −512 LSB and 0x3FF is +511 LSB. In automatic mode, `dac_code_o` = 0x200.
- R8: `pix_o` follows `pix_i` with a latency of exactly one clock in both modes.
- R9: During reset, `pix_o` = 0, `dac_code_o` = 0x200 and the correction is zero.
- R10: A `line_end_i` pulse without a completed window in that line leaves the correction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_i | input | 10 | Incoming pixel sample |
| win_start_i | input | 1 | Strobe on the first black-window sample |
| line_end_i | input | 1 | One-cycle pulse at the end of each line |
| auto_en_i | input | 1 | 1: automatic loop, 0: manual offset code |
| win_sel_i | input | 2 | Black window length select |
| bw_sel_i | input | 3 | Loop time constant select |
| half_range_i | input | 1 | 1: correction weight halved |
| target_i | input | 10 | Desired black level |
| man_off_i | input | 10 | Manual offset code, 0x200 = zero |
| pix_o | output | 10 | Corrected pixel |
| dac_code_o | output | 10 | Offset code for the analog stage |

## Verification
On every cycle, the assertions check the following:
- the integrator stays still outside qualified line ends;
- each step moves in the direction of the black error;
- a new average appears only after a window closes;
- manual mode passes pixels straight through;
- the offset code is neutral in automatic mode.

The directed scenarios show the rest:
- the exact averaging lengths, using ramps whose averages differ per window size;
- the time constants, as the line count at which the correction first reaches one LSB;
- saturation of both the correction and the output;
- the halved range;
- equal one-cycle latency in both modes.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int unsigned PIX_W        = 10;
  localparam int unsigned WIN_BASE_LOG = 4;
  localparam int unsigned WIN_SEL_W    = 2;
  localparam int unsigned BW_BASE_LOG  = 5;
  localparam int unsigned BW_SEL_W     = 3;
  localparam int unsigned FRAC_W       = 12;
endpackage

// File: rtl/blc_win_avg.sv
module blc_win_avg import blc_pkg::*; #(
  parameter int unsigned DW       = PIX_W,
  parameter int unsigned BASE_LOG = WIN_BASE_LOG,
  parameter int unsigned SEL_W    = WIN_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    pix_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             consume_i,
  output logic [DW-1:0]    avg_o,
  output logic             avg_vld_o
);
  localparam int unsigned MAX_LOG = BASE_LOG + (1 << SEL_W) - 1;
  localparam int unsigned ACC_W   = DW + MAX_LOG;
  localparam int unsigned CNT_W   = MAX_LOG + 1;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic [LOG_W-1:0] n_log;
  logic             busy_q;

  always_comb begin
    n_log    = LOG_W'(BASE_LOG) + LOG_W'(sel_i);
    last_idx = (CNT_W'(1) << n_log) - CNT_W'(1);
    acc_sum  = acc_q + ACC_W'(pix_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      avg_o     <= '0;
      avg_vld_o <= 1'b0;
    end else begin
      if (consume_i) avg_vld_o <= 1'b0;
      if (start_i) begin
        // window restarts on the strobe sample
        acc_q  <= ACC_W'(pix_i);
        cnt_q  <= CNT_W'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_sum;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == last_idx) begin
          busy_q    <= 1'b0;
          avg_o     <= DW'(acc_sum >> n_log);
          avg_vld_o <= 1'b1;
        end
      end
    end
  end

  // R1: a fresh average only after an open window closes
  p_avg_after_win_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avg_vld_o) |-> $past(busy_q));
endmodule

// File: rtl/blc_loop.sv
module blc_loop import blc_pkg::*; #(
  parameter int unsigned DW      = PIX_W,
  parameter int unsigned FRAC    = FRAC_W,
  parameter int unsigned BW_BASE = BW_BASE_LOG,
  parameter int unsigned BW_W    = BW_SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        avg_i,
  input  logic                 avg_vld_i,
  input  logic                 line_end_i,
  input  logic [DW-1:0]        target_i,
  input  logic [BW_W-1:0]      bw_sel_i,
  output logic signed [DW-1:0] corr_o
);
  localparam int unsigned IW = DW + FRAC;
  localparam int unsigned SW = IW + 2;
  localparam int unsigned EW = DW + 2;
  localparam logic signed [SW-1:0] HI = SW'((64'sd1 <<< (IW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [IW-1:0] integ_q;
  logic signed [EW-1:0] err;
  logic signed [SW-1:0] step, sum;
  logic                 upd;
  int unsigned          sh;

  always_comb begin
    upd  = line_end_i && avg_vld_i;
    err  = $signed({2'b00, target_i}) - $signed({2'b00, avg_i});
    sh   = FRAC - BW_BASE - int'(bw_sel_i);
    step = SW'(err) <<< sh;
    sum  = SW'(integ_q) + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       integ_q <= '0;
    else if (upd) begin
      if (sum > HI)      integ_q <= IW'(HI);
      else if (sum < LO) integ_q <= IW'(LO);
      else               integ_q <= IW'(sum);
    end
  end

  assign corr_o = integ_q[IW-1:FRAC];

  // R10: no qualified line end, no movement
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_end_i && avg_vld_i) |=> $stable(integ_q));
  // R2: step follows the sign of the black error
  p_step_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && avg_vld_i && (target_i > avg_i)) |=> integ_q >= $past(integ_q));
  p_step_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && avg_vld_i && (target_i < avg_i)) |=> integ_q <= $past(integ_q));
endmodule

// File: rtl/blc_out.sv
module blc_out import blc_pkg::*; #(
  parameter int unsigned DW = PIX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        pix_i,
  input  logic signed [DW-1:0] corr_i,
  input  logic                 auto_en_i,
  input  logic                 half_range_i,
  input  logic [DW-1:0]        man_off_i,
  output logic [DW-1:0]        pix_o,
  output logic [DW-1:0]        dac_code_o
);
  localparam logic signed [DW+1:0] MAXV    = (DW+2)'((1 << DW) - 1);
  localparam logic [DW-1:0]        NEUTRAL = DW'(1 << (DW - 1));

  logic signed [DW-1:0] adj;
  logic signed [DW+1:0] sum;
  logic [DW-1:0]        sat;

  always_comb begin
    adj = half_range_i ? (corr_i >>> 1) : corr_i;
    sum = $signed({2'b00, pix_i}) + (DW+2)'(adj);
    if (sum < 0)         sat = '0;
    else if (sum > MAXV) sat = MAXV[DW-1:0];
    else                 sat = sum[DW-1:0];
  end

  // same single register stage whether the adder is used or bypassed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o      <= '0;
      dac_code_o <= NEUTRAL;
    end else begin
      pix_o      <= auto_en_i ? sat : pix_i;
      dac_code_o <= auto_en_i ? NEUTRAL : man_off_i;
    end
  end

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> pix_o == $past(pix_i));
  p_dac_neutral_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i |=> dac_code_o == NEUTRAL);
  p_zero_corr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && corr_i == 0) |=> pix_o == $past(pix_i));
endmodule

// File: rtl/blc_top.sv
module blc_top import blc_pkg::*; #(
  parameter int unsigned DW       = PIX_W,
  parameter int unsigned SEL_W    = WIN_SEL_W,
  parameter int unsigned BW_W     = BW_SEL_W,
  parameter int unsigned FRAC     = FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    pix_i,
  input  logic             win_start_i,
  input  logic             line_end_i,
  input  logic             auto_en_i,
  input  logic [SEL_W-1:0] win_sel_i,
  input  logic [BW_W-1:0]  bw_sel_i,
  input  logic             half_range_i,
  input  logic [DW-1:0]    target_i,
  input  logic [DW-1:0]    man_off_i,
  output logic [DW-1:0]    pix_o,
  output logic [DW-1:0]    dac_code_o
);
  logic [DW-1:0]        avg;
  logic                 avg_vld;
  logic signed [DW-1:0] corr;

  blc_win_avg #(.DW(DW), .BASE_LOG(WIN_BASE_LOG), .SEL_W(SEL_W)) u_avg (
    .clk_i, .rst_ni, .pix_i, .start_i(win_start_i), .sel_i(win_sel_i),
    .consume_i(line_end_i), .avg_o(avg), .avg_vld_o(avg_vld)
  );

  blc_loop #(.DW(DW), .FRAC(FRAC), .BW_BASE(BW_BASE_LOG), .BW_W(BW_W)) u_loop (
    .clk_i, .rst_ni, .avg_i(avg), .avg_vld_i(avg_vld), .line_end_i,
    .target_i, .bw_sel_i, .corr_o(corr)
  );

  blc_out #(.DW(DW)) u_out (
    .clk_i, .rst_ni, .pix_i, .corr_i(corr), .auto_en_i, .half_range_i,
    .man_off_i, .pix_o, .dac_code_o
  );
endmodule

// File: tb/tb_blc_top.sv
module tb_blc_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] pix_i = '0;
  logic       win_start_i = 1'b0, line_end_i = 1'b0;
  logic       auto_en_i = 1'b1, half_range_i = 1'b0;
  logic [1:0] win_sel_i = 2'b00;
  logic [2:0] bw_sel_i = 3'b000;
  logic [9:0] target_i = '0, man_off_i = 10'h200;
  logic [9:0] pix_o, dac_code_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  blc_top dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; auto_en_i = 1'b1; half_range_i = 1'b0;
    pix_i = '0; win_start_i = 0; line_end_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one line: window of 2^(4+sel) samples base+ramp*i, then a line-end pulse
  task automatic run_line(int base, int ramp);
    int n = 1 << (4 + int'(win_sel_i));
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      win_start_i = (i == 0);
      pix_i = 10'(base + ramp * i);
    end
    @(negedge clk_i); win_start_i = 0; pix_i = '0;
    repeat (2) @(negedge clk_i);
    line_end_i = 1;
    @(negedge clk_i); line_end_i = 0;
    @(negedge clk_i);
  endtask

  task automatic probe(string tag, int p, int exp);
    @(negedge clk_i); pix_i = 10'(p);
    @(negedge clk_i); chk(tag, int'(pix_o), exp);
  endtask

  task automatic t_reset();
    @(negedge clk_i); rst_ni = 0;
    #1;
    chk("R9 pix_o in reset", int'(pix_o), 0);
    chk("R9 dac_code_o in reset", int'(dac_code_o), 512);
    do_reset();
    probe("R9 zero correction after reset", 321, 321);
  endtask

  task automatic t_windows();
    // ramps: window length changes the average
    do_reset(); win_sel_i = 2'b01; target_i = 47; bw_sel_i = 0;
    repeat (4) run_line(0, 1);
    probe("R1 32-sample ramp avg 15", 200, 204);
    do_reset(); win_sel_i = 2'b11; target_i = 95;
    repeat (2) run_line(0, 1);
    probe("R1 128-sample ramp avg 63", 200, 202);
    do_reset(); win_sel_i = 2'b10; target_i = 63;
    run_line(0, 1);
    probe("R2 64-sample ramp one line", 200, 201);
  endtask

  task automatic t_bandwidth();
    do_reset(); win_sel_i = 0; bw_sel_i = 3'b100; target_i = 32;
    repeat (15) run_line(0, 0);
    probe("R3 bw 512 after 15 lines", 500, 500);
    run_line(0, 0);
    probe("R3 bw 512 after 16 lines", 500, 501);
    do_reset(); bw_sel_i = 3'b111; target_i = 512;
    repeat (7) run_line(0, 0);
    probe("R3 bw 4096 after 7 lines", 500, 500);
    run_line(0, 0);
    probe("R3 bw 4096 after 8 lines", 500, 501);
  endtask

  task automatic t_no_window();
    repeat (3) begin
      @(negedge clk_i); line_end_i = 1;
      @(negedge clk_i); line_end_i = 0;
    end
    probe("R10 line end without window", 500, 501);
  endtask

  task automatic t_sat_hi();
    do_reset(); win_sel_i = 0; bw_sel_i = 0; target_i = 1023;
    repeat (20) run_line(0, 0);
    probe("R4 correction clamps at +511", 100, 611);
    probe("R6 output clamps at 1023", 1000, 1023);
    half_range_i = 1;
    probe("R5 half range +511", 100, 355);
    half_range_i = 0;
  endtask

  task automatic t_sat_lo();
    do_reset(); target_i = 0;
    repeat (20) run_line(1000, 0);
    probe("R6 output clamps at 0", 100, 0);
    probe("R4 correction clamps at -512", 700, 188);
    half_range_i = 1;
    probe("R5 half range -512", 700, 444);
    half_range_i = 0;
  endtask

  task automatic t_manual();
    @(negedge clk_i); auto_en_i = 0; man_off_i = 10'h000;
    probe("R7 manual bypass", 300, 300);
    chk("R7 dac code 0x000", int'(dac_code_o), 0);
    @(negedge clk_i); man_off_i = 10'h3FF;
    @(negedge clk_i); chk("R7 dac code 0x3FF", int'(dac_code_o), 1023);
    @(negedge clk_i); auto_en_i = 1;
    @(negedge clk_i); chk("R7 dac neutral in auto", int'(dac_code_o), 512);
  endtask

  task automatic t_latency();
    // correction is -512 here: auto 700 -> 188
    @(negedge clk_i); auto_en_i = 1; pix_i = 10'd700;
    @(negedge clk_i); pix_i = 10'd900;
    #1 chk("R8 auto old value held", int'(pix_o), 188);
    @(negedge clk_i); chk("R8 auto one-cycle", int'(pix_o), 388);
    auto_en_i = 0; pix_i = 10'd700;
    @(negedge clk_i); pix_i = 10'd900;
    #1 chk("R8 manual old value held", int'(pix_o), 700);
    @(negedge clk_i); chk("R8 manual one-cycle", int'(pix_o), 900);
    auto_en_i = 1;
  endtask

  initial begin
    t_reset();
    t_windows();
    t_bandwidth();
    t_no_window();
    t_sat_hi();
    t_sat_lo();
    t_manual();
    t_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule